// File: doc/BRIEF.md
# Indexed Byte Store Port with Lockable Windows

This block puts a byte-wide store behind a four-address I/O window that starts at a configurable base address. The host selects a location in two steps. It writes the low and high bytes of a 16-bit index through two port offsets. It then moves data through a third offset, which reads or writes the byte at that index. The fourth offset in the window is unused.

Two lock bits each hide a fixed 16-byte window of the index space. When a lock bit is set, writes to its window are discarded and reads from it return 0xFF. The rest of the array stays reachable. Each lock bit changes only through a toggle pulse that names it. Two kinds of location never reach storage through this path: a reserved 16-index range just below 8 KiB, and every index at or beyond the configured size.

The store is a synchronous byte array with one cycle of read latency. During that cycle the port lowers its ready output.

Top module: `nvp_port`

## Requirements
- R1: After reset the index is 0x0000, both lock bits are clear, `io_ready` is 1 and `io_rdata` is 0xFF.
- R2: An access is decoded only when `io_addr - BASE_ADDR` (16-bit arithmetic) is 0 to 3. A write at any other address has no effect. A read at any other address returns 0xFF one cycle later without a stall.
- R3: A write to offset 0 loads index bits [7:0] and keeps bits [15:8]. A write to offset 1 loads bits [15:8] and keeps bits [7:0]. A write to offset 2 changes nothing.
- R4: A write to offset 3 stores `io_wdata` at the current index when that index is accessible.
- R5: A read at offset 3 drives `io_ready` to 0 for exactly the cycle after it is accepted. On the following edge, `io_ready` returns to 1 and `io_rdata` shows the byte at the index, or 0xFF if the index is not accessible. `io_rdata` then holds until the next read.
- R6: A read at offset 0, 1 or 2 gives `io_rdata` = 0xFF on the next edge, and `io_ready` stays 1.
- R7: While lock bit 0 is set, indices 0x0020 to 0x002F are not accessible: a write there is dropped and a read there returns 0xFF.
- R8: While lock bit 1 is set, indices 0x0030 to 0x003F are not accessible in the same way.
- R9: A `lock_tgl` pulse inverts lock bit `lock_sel` and leaves the other bit unchanged. A location in a window that was hidden becomes readable again with its earlier contents once its lock is cleared.
- R10: Indices 0x1FF0 to 0x1FFF are never stored through the port. Reads there return 0xFF.
- R11: Indices at or above `MEM_BYTES` are never stored. Reads there return 0xFF.
- R12: Port requests presented while `io_ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Port access request, one per cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O address of the access |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, registered |
| io_ready | output | 1 | 0 while a data read is in flight |
| lock_tgl | input | 1 | Pulse: invert the selected lock bit |
| lock_sel | input | 1 | Lock bit number for `lock_tgl` |

## Verification
Index and data writes take effect at the edge that accepts them. A read at an auxiliary offset or outside the window returns its 0xFF on that same edge. A data-port read takes two edges: ready is low after the first edge, and the byte appears after the second. The bench drives every request at a falling edge and holds it for exactly one cycle. It samples ready at the falling edge after the accepting edge and samples read data one falling edge later. The stall test places a competing request in the ready-low cycle and then reads back the state that request would have changed.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

    localparam int unsigned NUM_LOCKS = 2;

    // 16-byte block numbers (index[15:4])
    localparam logic [11:0] LOCK_BLK0 = 12'h002;  // lock n hides block LOCK_BLK0 + n
    localparam logic [11:0] RSV_BLK   = 12'h1FF;  // reserved control range

    typedef enum logic [1:0] {
        OFS_IDX_LO = 2'd0,
        OFS_IDX_HI = 2'd1,
        OFS_SPARE  = 2'd2,
        OFS_DATA   = 2'd3
    } port_ofs_e;

    typedef struct packed {
        logic [15:0]          idx;
        logic [NUM_LOCKS-1:0] lock;
        logic                 pend;
        logic                 ok;
        logic [7:0]           rdat;
    } nvp_state_t;

endpackage

// File: rtl/nvp_decode.sv
module nvp_decode
    import nvp_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0074
) (
    input  logic [15:0] addr,
    output logic        hit,
    output port_ofs_e   ofs
);
    logic [15:0] rel;

    always_comb begin
        rel = addr - BASE_ADDR;
        hit = (rel[15:2] == 14'd0);
        ofs = port_ofs_e'(rel[1:0]);
    end
endmodule

// File: rtl/nvp_gate.sv
module nvp_gate
    import nvp_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 2048
) (
    input  logic [15:0]          idx,
    input  logic [NUM_LOCKS-1:0] lock,
    output logic                 allow
);
    localparam logic [16:0] SIZE = 17'(MEM_BYTES);

    logic [NUM_LOCKS-1:0] hidden;

    for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_win
        localparam logic [11:0] WIN = LOCK_BLK0 + 12'(n);
        assign hidden[n] = lock[n] && (idx[15:4] == WIN);
    end

    logic reserved;
    logic in_size;

    always_comb begin
        reserved = (idx[15:4] == RSV_BLK);
        in_size  = ({1'b0, idx} < SIZE);
        allow    = in_size && !reserved && (hidden == '0);
    end
endmodule

// File: rtl/nvp_store.sv
module nvp_store #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/nvp_port.sv
module nvp_port
    import nvp_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0074,
    parameter int unsigned MEM_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_sel,
    input  logic        io_we,
    input  logic [15:0] io_addr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        io_ready,
    input  logic        lock_tgl,
    input  logic        lock_sel
);
    localparam int unsigned AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

    nvp_state_t st_d, st_q;

    logic                 hit;
    port_ofs_e            ofs;
    logic                 allow;
    logic                 mem_we;
    logic [7:0]           mem_rd;
    logic [AW-1:0]        mem_addr;
    logic [15:0]          cur_idx;
    logic [NUM_LOCKS-1:0] cur_lock;

    nvp_decode #(.BASE_ADDR(BASE_ADDR)) u_decode (
        .addr (io_addr),
        .hit  (hit),
        .ofs  (ofs)
    );

    nvp_gate #(.MEM_BYTES(MEM_BYTES)) u_gate (
        .idx   (st_q.idx),
        .lock  (st_q.lock),
        .allow (allow)
    );

    nvp_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (io_wdata),
        .raddr (mem_addr),
        .rdata (mem_rd)
    );

    assign io_ready = !st_q.pend;
    assign io_rdata = st_q.rdat;
    assign cur_idx  = st_q.idx;
    assign cur_lock = st_q.lock;
    assign mem_addr = allow ? st_q.idx[AW-1:0] : '0;

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;

        if (lock_tgl) begin
            st_d.lock[lock_sel] = ~st_q.lock[lock_sel];
        end

        // second edge of a data read: present the array byte
        if (st_q.pend) begin
            st_d.pend = 1'b0;
            st_d.rdat = st_q.ok ? mem_rd : 8'hFF;
        end

        if (io_sel && io_ready) begin
            if (!io_we) begin
                if (hit && ofs == OFS_DATA) begin
                    st_d.pend = 1'b1;
                    st_d.ok   = allow;
                end else begin
                    st_d.rdat = 8'hFF;
                end
            end else if (hit) begin
                unique case (ofs)
                    OFS_IDX_LO: st_d.idx[7:0]  = io_wdata;
                    OFS_IDX_HI: st_d.idx[15:8] = io_wdata;
                    OFS_DATA:   mem_we         = allow;
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{idx: 16'h0000, lock: '0, pend: 1'b0, ok: 1'b0, rdat: 8'hFF};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/nvp_chk.sv
module nvp_chk #(
    parameter logic [15:0] BASE_ADDR = 16'h0074,
    parameter int unsigned MEM_BYTES = 2048
) (
    input logic        clk,
    input logic        rst_n,
    input logic        io_sel,
    input logic        io_we,
    input logic [15:0] io_addr,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        io_ready,
    input logic        lock_tgl,
    input logic        lock_sel,
    input logic [15:0] idx,
    input logic [1:0]  lock,
    input logic        mem_we
);
    logic [15:0] rel;
    logic        in_win;
    logic        take;

    assign rel    = io_addr - BASE_ADDR;
    assign in_win = (rel < 16'd4);
    assign take   = io_sel && io_ready;

    // R5: a data read stalls exactly one cycle
    a_r5_stall_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !io_we && in_win && rel[1:0] == 2'd3) |=> !io_ready);
    a_r5_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ready |=> io_ready);

    // R6 / R2: other reads return 0xFF without stalling
    a_r6_aux_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !io_we && !(in_win && rel[1:0] == 2'd3)) |=> (io_rdata == 8'hFF && io_ready));

    // R3: byte-wise index loads
    a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (take && io_we && in_win && rel[1:0] == 2'd0)
        |=> idx == {$past(idx[15:8]), $past(io_wdata)});
    a_r3_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (take && io_we && in_win && rel[1:0] == 2'd1)
        |=> idx == {$past(io_wdata), $past(idx[7:0])});

    // R9: a toggle flips only the named bit
    a_r9_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tgl |=> lock[$past(lock_sel)] != $past(lock[lock_sel]));
    a_r9_toggle_other: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tgl |=> lock[!$past(lock_sel)] == $past(lock[!lock_sel]));

    // R7, R8: no store into a hidden window
    a_r7_r8_lock_guard: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(lock[0] && idx[15:4] == 12'h002) && !(lock[1] && idx[15:4] == 12'h003));

    // R10, R11: no store into reserved or out-of-size indices
    a_r10_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (idx[15:4] != 12'h1FF) && ({1'b0, idx} < 17'(MEM_BYTES)));

    // R12: nothing moves the index during a stall
    a_r12_stall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ready |=> $stable(idx));

    // R4: storing only happens on a data-port write
    a_r4_store_source: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (take && io_we && in_win && rel[1:0] == 2'd3));
endmodule

bind nvp_port nvp_chk #(.BASE_ADDR(BASE_ADDR), .MEM_BYTES(MEM_BYTES)) u_nvp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_sel   (io_sel),
    .io_we    (io_we),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .io_ready (io_ready),
    .lock_tgl (lock_tgl),
    .lock_sel (lock_sel),
    .idx      (cur_idx),
    .lock     (cur_lock),
    .mem_we   (mem_we)
);

// File: tb/test_nvp_port.sv
`timescale 1ns/1ps
module test_nvp_port;
    localparam logic [15:0] BASE = 16'h0074;
    localparam int unsigned SIZE = 8208;  // 0x2010: covers the reserved range and a bit beyond

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0;
    logic        io_we = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_ready;
    logic        lock_tgl = 1'b0;
    logic        lock_sel = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [1:0] lk = 2'b00;

    always #4 clk = ~clk;

    nvp_port #(.BASE_ADDR(BASE), .MEM_BYTES(SIZE)) i_nvp_port (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
        .lock_tgl(lock_tgl), .lock_sel(lock_sel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i & 8'hFF) * 3 + (i >> 8) * 7 + seed * 29);
    endfunction

    function automatic bit reachable(input int i);
        if (i >= SIZE) return 1'b0;
        if (i >= 'h1FF0 && i <= 'h1FFF) return 1'b0;
        if (lk[0] && i >= 'h20 && i <= 'h2F) return 1'b0;
        if (lk[1] && i >= 'h30 && i <= 'h3F) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string tag_of(input int i);
        if (i >= SIZE) return "R11";
        if (i >= 'h1FF0 && i <= 'h1FFF) return "R10";
        if (lk[0] && i >= 'h20 && i <= 'h2F) return "R7";
        if (lk[1] && i >= 'h30 && i <= 'h3F) return "R8";
        return "R4";
    endfunction

    task automatic port_wr(input logic [15:0] addr, input logic [7:0] d);
        @(negedge clk);
        io_sel = 1'b1; io_we = 1'b1; io_addr = addr; io_wdata = d;
        @(negedge clk);
        io_sel = 1'b0; io_we = 1'b0;
    endtask

    task automatic aux_rd(input logic [15:0] addr, input string tag);
        @(negedge clk);
        io_sel = 1'b1; io_we = 1'b0; io_addr = addr;
        @(negedge clk);
        io_sel = 1'b0;
        chk(io_rdata == 8'hFF, tag, io_rdata, 8'hFF);
        chk(io_ready == 1'b1, tag, io_ready, 1);
    endtask

    task automatic data_rd(output logic [7:0] v);
        @(negedge clk);
        io_sel = 1'b1; io_we = 1'b0; io_addr = BASE + 16'd3;
        @(negedge clk);
        io_sel = 1'b0;
        chk(io_ready == 1'b0, "R5 stall", io_ready, 0);
        @(negedge clk);
        chk(io_ready == 1'b1, "R5 resume", io_ready, 1);
        v = io_rdata;
    endtask

    task automatic set_idx(input int i);
        port_wr(BASE, 8'(i));
        port_wr(BASE + 16'd1, 8'(i >> 8));
    endtask

    task automatic put(input int i, input logic [7:0] d);
        set_idx(i);
        port_wr(BASE + 16'd3, d);
    endtask

    task automatic expect_at(input int i, input logic [7:0] e, input string tag);
        logic [7:0] v;
        set_idx(i);
        data_rd(v);
        chk(v == e, tag, v, e);
    endtask

    task automatic toggle(input int n);
        @(negedge clk);
        lock_tgl = 1'b1; lock_sel = n[0];
        @(negedge clk);
        lock_tgl = 1'b0;
        lk[n] = ~lk[n];
    endtask

    // index segments swept: low area, around the reserved range and size edge, top of space
    task automatic sweep(input bit do_write, input int seed);
        int lo [3] = '{'h0000, 'h1FE0, 'hFFF0};
        int hi [3] = '{'h007F, 'h201F, 'hFFFF};
        for (int s = 0; s < 3; s++) begin
            for (int i = lo[s]; i <= hi[s]; i++) begin
                if (do_write) put(i, pat(i, seed));
                else expect_at(i, reachable(i) ? pat(i, seed) : 8'hFF, tag_of(i));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(io_ready == 1'b1, "R1 ready", io_ready, 1);
        chk(io_rdata == 8'hFF, "R1 rdata", io_rdata, 8'hFF);
        put(16'h0000, 8'h3C);          // index 0 must be addressable from reset
        expect_at(16'h0000, 8'h3C, "R1 index");

        // R3: byte-wise index loads
        put(16'h0140, 8'hA1);
        put(16'h0141, 8'hB2);
        set_idx(16'h0140);
        data_rd(v); chk(v == 8'hA1, "R3 full index", v, 8'hA1);
        port_wr(BASE, 8'h41);          // low byte only, high byte kept at 0x01
        data_rd(v); chk(v == 8'hB2, "R3 keep high", v, 8'hB2);
        put(16'h0241, 8'hC3);
        set_idx(16'h0141);
        port_wr(BASE + 16'd1, 8'h02);  // high byte only, low byte kept at 0x41
        data_rd(v); chk(v == 8'hC3, "R3 keep low", v, 8'hC3);

        // R4, R10, R11: sweep with locks clear
        sweep(1'b1, 1);
        sweep(1'b0, 1);

        // R7, R9: lock 0
        toggle(0);
        for (int i = 'h20; i <= 'h3F; i++) put(i, pat(i, 2));
        for (int i = 'h20; i <= 'h2F; i++) expect_at(i, 8'hFF, "R7 hidden");
        for (int i = 'h30; i <= 'h3F; i++) expect_at(i, pat(i, 2), "R7 neighbour");
        expect_at('h40, pat('h40, 1), "R7 outside");
        toggle(0);
        for (int i = 'h20; i <= 'h2F; i++) expect_at(i, pat(i, 1), "R9 unlock0");

        // R8, R9: lock 1
        toggle(1);
        for (int i = 'h30; i <= 'h3F; i++) expect_at(i, 8'hFF, "R8 hidden");
        for (int i = 'h20; i <= 'h3F; i++) put(i, pat(i, 3));
        expect_at('h2F, pat('h2F, 3), "R8 neighbour");
        toggle(1);
        for (int i = 'h20; i <= 'h2F; i++) expect_at(i, pat(i, 3), "R9 after1");
        for (int i = 'h30; i <= 'h3F; i++) expect_at(i, pat(i, 2), "R9 unlock1");

        // R9: both locks set, one cleared again
        toggle(0); toggle(1); toggle(0);
        expect_at('h25, pat('h25, 3), "R9 lock0 off");
        expect_at('h35, 8'hFF, "R9 lock1 on");
        toggle(1);
        expect_at('h35, pat('h35, 2), "R9 lock1 off");

        // R6: auxiliary offsets read 0xFF without stall, right after a real byte
        expect_at('h11, pat('h11, 1), "R6 setup");
        aux_rd(BASE, "R6 ofs0");
        aux_rd(BASE + 16'd1, "R6 ofs1");
        aux_rd(BASE + 16'd2, "R6 ofs2");

        // R2: outside the window
        aux_rd(BASE - 16'd1, "R2 below");
        aux_rd(BASE + 16'd4, "R2 above");
        aux_rd(BASE + 16'd7, "R2 alias");
        set_idx('h10);
        port_wr(BASE + 16'd4, 8'h55);   // would be the low index byte if aliased
        port_wr(BASE + 16'd7, 8'hAA);   // would be a data write if aliased
        port_wr(BASE - 16'd1, 8'h66);
        port_wr(BASE + 16'd2, 8'h77);   // R3: spare offset
        data_rd(v); chk(v == pat('h10, 1), "R2 no effect", v, pat('h10, 1));
        set_idx('h55);
        data_rd(v); chk(v == pat('h55, 1), "R3 spare/R2 index", v, pat('h55, 1));

        // R12: request during the stall cycle is ignored
        set_idx('h50);
        @(negedge clk);
        io_sel = 1'b1; io_we = 1'b0; io_addr = BASE + 16'd3;
        @(negedge clk);
        chk(io_ready == 1'b0, "R12 stall", io_ready, 0);
        io_we = 1'b1; io_wdata = 8'hC3;       // data write while not ready
        @(negedge clk);
        io_sel = 1'b0; io_we = 1'b0;
        chk(io_rdata == pat('h50, 1), "R12 read", io_rdata, pat('h50, 1));
        data_rd(v); chk(v == pat('h50, 1), "R12 ignored write", v, pat('h50, 1));
        @(negedge clk);
        io_sel = 1'b1; io_we = 1'b0; io_addr = BASE + 16'd3;
        @(negedge clk);
        io_we = 1'b1; io_addr = BASE; io_wdata = 8'h51;   // index write while not ready
        @(negedge clk);
        io_sel = 1'b0; io_we = 1'b0;
        data_rd(v); chk(v == pat('h50, 1), "R12 ignored index", v, pat('h50, 1));

        finish_run();
    end
endmodule